// File: doc/BRIEF.md
# Microcontroller Power-Mode Controller

This block decides when the core of a small 8-bit microcontroller sleeps and when it wakes. Software writes a two-bit mode field. One bit selects a light sleep, in which only the CPU clock stops. The other selects a deep sleep, in which the CPU clock and the peripheral clock both stop. While either sleep lasts, the block holds the bus strobes at fixed levels. Each level depends on which sleep is active.

A light sleep ends on any interrupt request or on an enabled external pin event. A deep sleep ends only through an enabled external pin that is configured as level-triggered. That pin must stay low for a minimum number of oscillator cycles and must then return high. Every exit clears its mode bit and sends a one-cycle wake pulse to the interrupt controller. A synchronous hardware reset leaves either sleep and returns the block to its power-on state. The block runs on the raw oscillator clock. It changes the clock enables only while that clock is low, so the gated clocks get no shortened pulses.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A write with `pwr_we` high and `pwr_mode_wr` = 2'b01 (bit 0) enters light sleep one cycle later. A write of 2'b00 changes nothing.
- R2: In light sleep, `cpu_clk_en` is 0 and `per_clk_en` stays 1.
- R3: Light sleep ends on any bit of `irq_req`. It also ends on an enabled external pin: a synchronized low if `ext_level` is 1, or a synchronized falling edge if `ext_level` is 0. On exit `mode_idle` clears and `wake_pulse` is high for exactly one cycle. A pin whose `ext_en` bit is 0 has no effect.
- R4: A write of 2'b10 (bit 1) enters deep sleep. In deep sleep `cpu_clk_en` and `per_clk_en` are both 0.
- R5: In deep sleep, `irq_req`, edge-mode pins (`ext_level` = 0) and disabled pins are ignored, however long they are asserted.
- R6: Deep sleep ends when an enabled level-mode pin, sampled low at HOLD_CYCLES (default 1024) or more consecutive rising edges, returns high. `mode_pd` clears and `wake_pulse` pulses three edges after the pin rises. A run of 1023 low samples does not wake the block.
- R7: `strobe_hold` is 1 during either sleep. `ale_level` and `psen_level` are 1 in light sleep and 0 in deep sleep.
- R8: A write of 2'b11 enters deep sleep, never light sleep. The two mode bits are never set together.
- R9: If the pin rises before the count is complete, the count restarts from zero. For example, 1000 low cycles, a short high, then 100 low cycles do not wake the block.
- R10: The clock enables change only on the falling edge of `clk_osc`. After a mode change, an enable is unchanged just after the next rising edge and takes its new value after the falling edge that follows.
- R11: With `rst` high, both mode bits clear, both clock enables become 1, `strobe_hold` and `wake_pulse` become 0, and any sleep is left.
- R12: Writes to the mode field while asleep are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| pwr_we | input | 1 | Mode field write strobe |
| pwr_mode_wr | input | 2 | Write data: bit 0 light sleep, bit 1 deep sleep |
| irq_req | input | N_IRQ | Enabled interrupt requests |
| ext_pin_n | input | N_EXT | Active-low external interrupt pins, asynchronous |
| ext_en | input | N_EXT | Per-pin enable |
| ext_level | input | N_EXT | Per-pin mode: 1 level-low, 0 falling edge |
| cpu_clk_en | output | 1 | CPU clock enable, changes on falling edge |
| per_clk_en | output | 1 | Peripheral clock enable, changes on falling edge |
| strobe_hold | output | 1 | Strobes are forced while high |
| ale_level | output | 1 | Forced address-latch strobe level |
| psen_level | output | 1 | Forced program-store strobe level |
| wake_pulse | output | 1 | One-cycle wake indication to the interrupt controller |
| mode_idle | output | 1 | Light-sleep bit |
| mode_pd | output | 1 | Deep-sleep bit |

## Verification
The assertions assume that `rst` is high from time zero and stays high for at least two rising edges. They also assume that inputs settle between clock edges, so a mode bit can fall only through a wake or a reset. The deep-sleep hold check counts raw pin samples, so it assumes a pin stays at each level long enough for the two-flop synchronizer to pass it on. The stimulus changes every input one nanosecond after a rising edge. It holds every pin level for at least three cycles and keeps reset high for three or more cycles. This keeps every transition visible to both the design and the checker.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned IDLE_POS = 0;
  localparam int unsigned PDN_POS  = 1;

  typedef struct packed {
    logic pdn;
    logic idle;
  } pm_bits_t;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic hold;
    logic ale;
    logic psen;
  } pm_out_t;

  localparam pm_out_t PM_OUT_RESET = '{cpu_en: 1'b1, per_en: 1'b1, hold: 1'b0,
                                       ale: 1'b1, psen: 1'b1};
endpackage

// File: rtl/pmc_pin_sync.sv
`timescale 1ns/1ps
module pmc_pin_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] pin_low,
  output logic [N-1:0] pin_fall
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '1;
      last_q <= '1;
    end else begin
      stg[0] <= pin_n;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      last_q <= stg[STAGES-1];
    end
  end

  assign pin_low  = ~stg[STAGES-1];
  assign pin_fall = last_q & ~stg[STAGES-1];
endmodule

// File: rtl/pmc_hold_timer.sv
`timescale 1ns/1ps
module pmc_hold_timer #(
  parameter int unsigned HOLD = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic pin_low,
  output logic release_ok
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD);

  logic [CW-1:0] cnt_q;

  // counts synchronized low samples; any high sample or disarm restarts it
  always_ff @(posedge clk) begin
    if (rst || !arm || !pin_low) cnt_q <= '0;
    else if (cnt_q != LIMIT)     cnt_q <= cnt_q + 1'b1;
  end

  assign release_ok = arm && !pin_low && (cnt_q == LIMIT);
endmodule

// File: rtl/pmc_mode_ctrl.sv
`timescale 1ns/1ps
module pmc_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned N_IRQ = 4,
  parameter int unsigned N_EXT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_EXT-1:0]  ext_idle_hit,
  input  logic [N_EXT-1:0]  pd_release,
  output pm_bits_t          mode,
  output logic              wake_pulse
);
  logic idle_exit, pd_exit, req_pd, req_idle;

  always_comb begin
    idle_exit = mode.idle && ((|irq_req) || (|ext_idle_hit));
    pd_exit   = mode.pdn && (|pd_release);
    req_pd    = wr_en && wr_mode[PDN_POS];
    req_idle  = wr_en && wr_mode[IDLE_POS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode       <= '0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      if (mode.pdn) begin
        if (pd_exit) begin
          mode.pdn   <= 1'b0;
          wake_pulse <= 1'b1;
        end
      end else if (mode.idle) begin
        if (idle_exit) begin
          mode.idle  <= 1'b0;
          wake_pulse <= 1'b1;
        end
      end else if (req_pd) begin
        mode.pdn <= 1'b1;
      end else if (req_idle) begin
        mode.idle <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pmc_clk_gate.sv
`timescale 1ns/1ps
module pmc_clk_gate
  import pmc_pkg::*;
#(
  parameter bit FALL_EDGE_GATE = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  pm_bits_t mode,
  output logic     cpu_clk_en,
  output logic     per_clk_en,
  output logic     strobe_hold,
  output logic     ale_level,
  output logic     psen_level
);
  pm_out_t nxt, stage_q;
  logic    asleep;

  always_comb begin
    asleep     = mode.idle || mode.pdn;
    nxt.cpu_en = !asleep;
    nxt.per_en = !mode.pdn;
    nxt.hold   = asleep;
    nxt.ale    = !mode.pdn;
    nxt.psen   = !mode.pdn;
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= PM_OUT_RESET;
    else     stage_q <= nxt;
  end

  generate
    if (FALL_EDGE_GATE) begin : g_fall
      logic cpu_q, per_q;
      always_ff @(negedge clk) begin
        if (rst) begin
          cpu_q <= 1'b1;
          per_q <= 1'b1;
        end else begin
          cpu_q <= stage_q.cpu_en;
          per_q <= stage_q.per_en;
        end
      end
      assign cpu_clk_en = cpu_q;
      assign per_clk_en = per_q;
    end else begin : g_rise
      assign cpu_clk_en = stage_q.cpu_en;
      assign per_clk_en = stage_q.per_en;
    end
  endgenerate

  assign strobe_hold = stage_q.hold;
  assign ale_level   = stage_q.ale;
  assign psen_level  = stage_q.psen;
endmodule

// File: rtl/pwr_mode_ctrl.sv
`timescale 1ns/1ps
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned N_IRQ       = 4,
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned HOLD_CYCLES = 1024,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_osc,
  input  logic              rst,
  input  logic              pwr_we,
  input  logic [MODE_W-1:0] pwr_mode_wr,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic [N_EXT-1:0]  ext_pin_n,
  input  logic [N_EXT-1:0]  ext_en,
  input  logic [N_EXT-1:0]  ext_level,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              strobe_hold,
  output logic              ale_level,
  output logic              psen_level,
  output logic              wake_pulse,
  output logic              mode_idle,
  output logic              mode_pd
);
  pm_bits_t         mode;
  logic [N_EXT-1:0] pin_low, pin_fall, idle_hit, pd_arm, pd_release;

  pmc_pin_sync #(.N(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_osc),
    .rst      (rst),
    .pin_n    (ext_pin_n),
    .pin_low  (pin_low),
    .pin_fall (pin_fall)
  );

  assign idle_hit = ext_en & ((ext_level & pin_low) | (~ext_level & pin_fall));
  assign pd_arm   = {N_EXT{mode.pdn}} & ext_en & ext_level;

  generate
    for (genvar i = 0; i < N_EXT; i++) begin : g_timer
      pmc_hold_timer #(.HOLD(HOLD_CYCLES)) u_timer (
        .clk        (clk_osc),
        .rst        (rst),
        .arm        (pd_arm[i]),
        .pin_low    (pin_low[i]),
        .release_ok (pd_release[i])
      );
    end
  endgenerate

  pmc_mode_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT)) u_mode (
    .clk          (clk_osc),
    .rst          (rst),
    .wr_en        (pwr_we),
    .wr_mode      (pwr_mode_wr),
    .irq_req      (irq_req),
    .ext_idle_hit (idle_hit),
    .pd_release   (pd_release),
    .mode         (mode),
    .wake_pulse   (wake_pulse)
  );

  pmc_clk_gate #(.FALL_EDGE_GATE(1'b1)) u_gate (
    .clk         (clk_osc),
    .rst         (rst),
    .mode        (mode),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .strobe_hold (strobe_hold),
    .ale_level   (ale_level),
    .psen_level  (psen_level)
  );

  assign mode_idle = mode.idle;
  assign mode_pd   = mode.pdn;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_chk #(
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned HOLD_CYCLES = 1024
) (
  input logic             clk_osc,
  input logic             rst,
  input logic [N_EXT-1:0] ext_pin_n,
  input logic             cpu_clk_en,
  input logic             per_clk_en,
  input logic             strobe_hold,
  input logic             ale_level,
  input logic             psen_level,
  input logic             wake_pulse,
  input logic             mode_idle,
  input logic             mode_pd
);
  localparam int unsigned RW = $clog2(HOLD_CYCLES + 1);
  localparam logic [RW-1:0] RLIM = RW'(HOLD_CYCLES);

  logic [N_EXT-1:0] last_ok;

  // raw low-run length per pin, remembered when the pin goes high
  generate
    for (genvar i = 0; i < N_EXT; i++) begin : g_run
      logic [RW-1:0] run_q;
      always_ff @(posedge clk_osc) begin
        if (rst) begin
          run_q      <= '0;
          last_ok[i] <= 1'b0;
        end else if (!ext_pin_n[i]) begin
          if (run_q != RLIM) run_q <= run_q + 1'b1;
        end else begin
          if (run_q != '0) last_ok[i] <= (run_q == RLIM);
          run_q <= '0;
        end
      end
    end
  endgenerate

  assert_idle_clocks_R2: assert property (@(posedge clk_osc) disable iff (rst)
    mode_idle |=> (!cpu_clk_en && per_clk_en));

  assert_pdown_clocks_R4: assert property (@(posedge clk_osc) disable iff (rst)
    mode_pd |=> (!cpu_clk_en && !per_clk_en));

  assert_strobe_idle_R7: assert property (@(posedge clk_osc) disable iff (rst)
    mode_idle |=> (strobe_hold && ale_level && psen_level));

  assert_strobe_pdown_R7: assert property (@(posedge clk_osc) disable iff (rst)
    mode_pd |=> (strobe_hold && !ale_level && !psen_level));

  assert_one_mode_R8: assert property (@(posedge clk_osc) disable iff (rst)
    !(mode_idle && mode_pd));

  assert_idle_exit_pulse_R3: assert property (@(posedge clk_osc) disable iff (rst)
    $fell(mode_idle) |-> wake_pulse);

  assert_pulse_width_R3: assert property (@(posedge clk_osc) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  assert_pdown_exit_pulse_R6: assert property (@(posedge clk_osc) disable iff (rst)
    $fell(mode_pd) |-> wake_pulse);

  assert_hold_met_R6: assert property (@(posedge clk_osc) disable iff (rst)
    $fell(mode_pd) |-> (|last_ok));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_EXT(N_EXT), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk_osc     (clk_osc),
  .rst         (rst),
  .ext_pin_n   (ext_pin_n),
  .cpu_clk_en  (cpu_clk_en),
  .per_clk_en  (per_clk_en),
  .strobe_hold (strobe_hold),
  .ale_level   (ale_level),
  .psen_level  (psen_level),
  .wake_pulse  (wake_pulse),
  .mode_idle   (mode_idle),
  .mode_pd     (mode_pd)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int NV = 19;

  logic       clk_osc = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_we = 1'b0;
  logic [1:0] pwr_mode_wr = 2'b00;
  logic [3:0] irq_req = 4'h0;
  logic [1:0] ext_pin_n = 2'b11;
  logic [1:0] ext_en = 2'b11;
  logic [1:0] ext_level = 2'b01;
  logic cpu_clk_en, per_clk_en, strobe_hold, ale_level, psen_level;
  logic wake_pulse, mode_idle, mode_pd;

  int n_chk = 0;
  int n_bad = 0;
  int n_wake = 0;
  bit finished = 1'b0;

  always #4 clk_osc = ~clk_osc;

  pwr_mode_ctrl dut_i (
    .clk_osc(clk_osc), .rst(rst), .pwr_we(pwr_we), .pwr_mode_wr(pwr_mode_wr),
    .irq_req(irq_req), .ext_pin_n(ext_pin_n), .ext_en(ext_en), .ext_level(ext_level),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .strobe_hold(strobe_hold),
    .ale_level(ale_level), .psen_level(psen_level), .wake_pulse(wake_pulse),
    .mode_idle(mode_idle), .mode_pd(mode_pd)
  );

  always @(negedge clk_osc) if (!rst && wake_pulse) n_wake++;

  // {we, mode[1:0], irq[3:0], pin_n[1:0], wait[10:0], exp{idle,pd,cpu,per,hold,ale}}
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 2'b01, 4'h0, 2'b11, 11'd5,    6'b100111},
    {1'b0, 2'b00, 4'h4, 2'b11, 11'd5,    6'b001101},
    {1'b1, 2'b00, 4'h0, 2'b11, 11'd5,    6'b001101},
    {1'b1, 2'b10, 4'h0, 2'b11, 11'd5,    6'b010010},
    {1'b0, 2'b00, 4'hF, 2'b11, 11'd5,    6'b010010},
    {1'b0, 2'b00, 4'h0, 2'b01, 11'd1100, 6'b010010},
    {1'b0, 2'b00, 4'h0, 2'b11, 11'd5,    6'b010010},
    {1'b0, 2'b00, 4'h0, 2'b10, 11'd1100, 6'b010010},
    {1'b0, 2'b00, 4'h0, 2'b11, 11'd5,    6'b001101},
    {1'b1, 2'b11, 4'h0, 2'b11, 11'd5,    6'b010010},
    {1'b0, 2'b00, 4'h0, 2'b10, 11'd1100, 6'b010010},
    {1'b0, 2'b00, 4'h0, 2'b11, 11'd5,    6'b001101},
    {1'b1, 2'b01, 4'h0, 2'b11, 11'd5,    6'b100111},
    {1'b1, 2'b10, 4'h0, 2'b11, 11'd5,    6'b100111},
    {1'b0, 2'b00, 4'h0, 2'b10, 11'd5,    6'b001101},
    {1'b0, 2'b00, 4'h0, 2'b11, 11'd5,    6'b001101},
    {1'b1, 2'b01, 4'h0, 2'b11, 11'd5,    6'b100111},
    {1'b0, 2'b00, 4'h0, 2'b01, 11'd5,    6'b001101},
    {1'b0, 2'b00, 4'h0, 2'b11, 11'd5,    6'b001101}
  };

  function automatic string row_tag(int r);
    case (r)
      0:       return "R1 R2 R7";
      1:       return "R3 irq";
      2:       return "R1 zero write";
      3:       return "R4 R7";
      4:       return "R5 irq";
      5, 6:    return "R5 edge pin";
      7:       return "R6 held low";
      8:       return "R6 release";
      9:       return "R8 both bits";
      10, 11:  return "R6 wake";
      12:      return "R1 idle";
      13:      return "R12 write asleep";
      14:      return "R3 level pin";
      16:      return "R1 idle again";
      17:      return "R3 edge pin";
      default: return "R3 settle";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk_osc);
    #1;
  endtask

  task automatic write_mode(input logic [1:0] m);
    tick(1);
    pwr_we = 1'b1; pwr_mode_wr = m;
    tick(1);
    pwr_we = 1'b0; pwr_mode_wr = 2'b00;
    tick(4);
  endtask

  task automatic hold_low(input int pin, input int n);
    ext_pin_n[pin] = 1'b0;
    repeat (n) @(posedge clk_osc);
    #1 ext_pin_n[pin] = 1'b1;
  endtask

  function automatic logic [31:0] outs6();
    return {26'd0, mode_idle, mode_pd, cpu_clk_en, per_clk_en, strobe_hold, ale_level};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk_osc);
    if (!finished) begin
      n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int w0;
    tick(5);
    rst = 1'b0;
    #4;
    // R11: reset state
    check("R11 reset modes/enables", outs6(), 32'b001101);
    check("R11 reset wake", {31'd0, wake_pulse}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      tick(1);
      pwr_we = VEC[v][25]; pwr_mode_wr = VEC[v][24:23];
      irq_req = VEC[v][22:19]; ext_pin_n = VEC[v][18:17];
      tick(1);
      pwr_we = 1'b0;
      repeat (int'(VEC[v][16:6])) @(posedge clk_osc);
      #5;
      check(row_tag(v), outs6(), {26'd0, VEC[v][5:0]});
      check(row_tag(v), {31'd0, psen_level}, {31'd0, VEC[v][0]});
    end
    irq_req = 4'h0; ext_pin_n = 2'b11;

    // R10: enable moves only after the falling edge
    tick(1);
    pwr_we = 1'b1; pwr_mode_wr = 2'b01;
    tick(1);
    pwr_we = 1'b0;
    tick(1);
    check("R10 enable before fall", {31'd0, cpu_clk_en}, 32'd1);
    #4;
    check("R10 enable after fall", {31'd0, cpu_clk_en}, 32'd0);

    // R3: disabled pin ignored in light sleep
    tick(1);
    ext_en = 2'b10;
    ext_pin_n[0] = 1'b0;
    tick(20);
    #4;
    check("R3 disabled pin ignored", {31'd0, mode_idle}, 32'd1);
    tick(1);
    ext_pin_n[0] = 1'b1;
    tick(4);
    ext_en = 2'b11;
    // R3: wake pulse exactly one cycle
    irq_req = 4'h1;
    tick(1);
    #4;
    check("R3 pulse high", {30'd0, wake_pulse, mode_idle}, 32'b10);
    tick(1);
    irq_req = 4'h0;
    #4;
    check("R3 pulse single", {31'd0, wake_pulse}, 32'd0);
    tick(3);

    // R6: 1023 low samples do not wake, 1024 do
    write_mode(2'b10);
    hold_low(0, 1023);
    tick(6);
    #4;
    check("R6 1023 low stays", {31'd0, mode_pd}, 32'd1);
    tick(1);
    w0 = n_wake;
    hold_low(0, 1024);
    tick(2);
    #4;
    check("R6 not yet after 2", {31'd0, mode_pd}, 32'd1);
    tick(1);
    #4;
    check("R6 wake after 3", {30'd0, mode_pd, wake_pulse}, 32'b01);
    tick(4);
    check("R6 one wake pulse", n_wake - w0, 32'd1);

    // R9: interrupted low run restarts the count
    write_mode(2'b10);
    hold_low(0, 1000);
    tick(3);
    hold_low(0, 100);
    tick(8);
    #4;
    check("R9 restart no wake", {31'd0, mode_pd}, 32'd1);

    // R5: disabled level pin ignored in deep sleep
    tick(1);
    ext_en = 2'b10;
    hold_low(0, 1100);
    tick(8);
    #4;
    check("R5 disabled pin", {31'd0, mode_pd}, 32'd1);
    tick(1);
    ext_en = 2'b11;

    // R11: reset leaves deep sleep
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    #4;
    check("R11 reset from deep", outs6(), 32'b001101);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule